// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel. It takes an 8-byte configuration descriptor in a single load, then copies items from a source location to a destination location in a 16-bit address space. It uses a simple synchronous memory port that performs one read and one write per item. Each item is either a byte or a 16-bit word. After each item the source and destination pointers move by a step chosen for each pointer: hold, forward one item, forward two items or back one item.

The number of items is either a fixed length from the descriptor or a length read from the data itself. For a data-derived length, the first item moved supplies a value n. A 3-bit length mode adds an offset of 0, 1, 2 or 3 to n, and the fixed length acts as a ceiling. A trigger selector decides what starts the work. One trigger can move a single item or the whole count, and the repeated modes reload the descriptor's pointers and count after each completion. Writes aimed at a parameterised flash window are dropped, but the pointers and the count still advance.

Top module: `dma_chan_engine`

## Requirements
- R1: The descriptor bus carries byte 0 in bits 63:56 and byte 7 in bits 7:0. The source address is bits 63:48 and the destination address is bits 47:32. The length mode is bits 31:29 and the 13-bit length is bits 28:16. Item width is bit 15 (0 = byte, 1 = word), the transfer mode is bits 14:13, the trigger select is bits 12:8, the source step is bits 7:6 and the destination step is bits 5:4.
- R2: Length modes 000 and 111 move exactly the descriptor length. A fixed length of zero raises done without any memory access.
- R3: Length modes 001, 010, 011 and 100 move n+1, n, n+2 and n+3 items. For words, n is the low 13 bits of the first word. For bytes, n is the whole first byte, or its low 7 bits when `len_byte_low7` was high at load.
- R4: In a data-derived mode, when n is greater than or equal to the descriptor length, the count is the descriptor length. The count is never below one, because the item holding n has already moved.
- R5: Length modes 101 and 110 complete at once with no read and no write, and the channel returns to idle.
- R6: Step codes 00, 01, 10 and 11 change a pointer by 0, +1, +2 and -1 items. An item is 1 byte for byte transfers and 2 bytes for word transfers.
- R7: A `sw_req` pulse starts the channel whatever the trigger select. Select 1 also accepts `prev_done`, and a select k of 2 or more also accepts `ext_trig[k-2]`. Every other trigger input has no effect.
- R8: Transfer mode 00 (single) moves one item per trigger, and mode 01 (block) moves the whole count on one trigger. In both modes the channel goes idle after the count is done.
- R9: Transfer modes 10 and 11 (repeated) reload the descriptor's pointers and count after completion and wait for the next trigger.
- R10: A write whose destination lies in [FLASH_BASE, FLASH_LAST] is not issued, yet it still counts as a moved item.
- R11: `done` is high for exactly one cycle per completed count.
- R12: Each item is one read followed, two cycles later, by one write. Read data is taken one cycle after the read request. `mem_wide` follows the item width, and the port is quiet while idle.
- R13: `desc_load` is ignored unless the channel is idle.
- R14: Reset is synchronous and active high. It leaves the channel idle with `mem_en`, `done` and `active` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| desc_load | input | 1 | Load the descriptor when idle |
| desc_bytes | input | 64 | Descriptor, byte 0 in the top bits |
| len_byte_low7 | input | 1 | Byte-mode n uses only the low 7 bits |
| sw_req | input | 1 | Software start request |
| prev_done | input | 1 | Completion of the preceding channel |
| ext_trig | input | NUM_EXT | External trigger inputs |
| mem_rdata | input | 16 | Read data, valid one cycle after a read request |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_wide | output | 1 | Access is 16-bit |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 16 | Write data |
| active | output | 1 | Channel is armed or transferring |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the engine with four external triggers and a flash window at 0xC0 to 0xFF. This places suppressed writes, and trigger selects whose input does not exist, inside a 256-byte memory model that the bench can check byte for byte. Each table vector uses its own length mode, step pair and item width. The bench compares the whole memory image against its own model of the copy. Directed runs then cover wrong-trigger rejection, loading while busy, repeated reload, a length of zero and the one-item floor.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  localparam int ADDR_W = 16;
  localparam int LEN_W  = 13;
  localparam int DATA_W = 16;
  localparam int CNT_W  = LEN_W + 1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ARM, ST_RD, ST_CAP, ST_WR, ST_FIN
  } dma_state_e;

  typedef struct packed {
    logic [ADDR_W-1:0] src;
    logic [ADDR_W-1:0] dst;
    logic [2:0]        vlen;
    logic [LEN_W-1:0]  len;
    logic              wide;
    logic [1:0]        tmode;
    logic [4:0]        trig;
    logic [1:0]        sinc;
    logic [1:0]        dinc;
  } dma_cfg_t;

  function automatic logic len_is_fixed(input logic [2:0] v);
    return (v == 3'b000) || (v == 3'b111);
  endfunction

  function automatic logic len_is_reserved(input logic [2:0] v);
    return (v == 3'b101) || (v == 3'b110);
  endfunction
endpackage

// File: rtl/dma_desc_unpack.sv
module dma_desc_unpack
  import dma_chan_pkg::*;
(
  input  logic [63:0] raw,
  output dma_cfg_t    cfg
);
  always_comb begin
    cfg.src   = raw[63:48];
    cfg.dst   = raw[47:32];
    cfg.vlen  = raw[31:29];
    cfg.len   = raw[28:16];
    cfg.wide  = raw[15];
    cfg.tmode = raw[14:13];
    cfg.trig  = raw[12:8];
    cfg.sinc  = raw[7:6];
    cfg.dinc  = raw[5:4];
  end
endmodule

// File: rtl/dma_trig_select.sv
module dma_trig_select #(
  parameter int NUM_EXT = 30
) (
  input  logic [4:0]         code,
  input  logic               sw_req,
  input  logic               prev_done,
  input  logic [NUM_EXT-1:0] ext_trig,
  output logic               hit
);
  localparam int NUM_CODES = 32;
  logic [NUM_CODES-1:0] cand;

  for (genvar k = 0; k < NUM_CODES; k++) begin : g_code
    if (k == 0) begin : g_none
      assign cand[k] = 1'b0;
    end else if (k == 1) begin : g_chain
      assign cand[k] = prev_done;
    end else if (k - 2 < NUM_EXT) begin : g_ext
      assign cand[k] = ext_trig[k-2];
    end else begin : g_absent
      assign cand[k] = 1'b0;
    end
  end

  assign hit = sw_req | cand[code];
endmodule

// File: rtl/dma_len_calc.sv
module dma_len_calc #(
  parameter int LEN_W = 13,
  localparam int CNT_W = LEN_W + 1
) (
  input  logic [2:0]       vlen,
  input  logic [LEN_W-1:0] len,
  input  logic             wide,
  input  logic             low7,
  input  logic [LEN_W-1:0] first_item,
  output logic [CNT_W-1:0] cnt
);
  logic [LEN_W-1:0] n;
  logic [CNT_W-1:0] vcnt;

  always_comb begin
    if (wide)      n = first_item;
    else if (low7) n = {{(LEN_W-7){1'b0}}, first_item[6:0]};
    else           n = {{(LEN_W-8){1'b0}}, first_item[7:0]};

    unique case (vlen)
      3'b001:  vcnt = {1'b0, n} + CNT_W'(1);
      3'b011:  vcnt = {1'b0, n} + CNT_W'(2);
      3'b100:  vcnt = {1'b0, n} + CNT_W'(3);
      default: vcnt = {1'b0, n};
    endcase

    if (n >= len) cnt = {1'b0, len};
    else          cnt = vcnt;
    if (cnt == '0) cnt = CNT_W'(1);
  end
endmodule

// File: rtl/dma_addr_step.sv
module dma_addr_step #(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [1:0]        inc_code,
  input  logic              wide,
  output logic [ADDR_W-1:0] addr_out
);
  logic [ADDR_W-1:0] delta;

  always_comb begin
    unique case (inc_code)
      2'b00:   delta = '0;
      2'b01:   delta = ADDR_W'(1);
      2'b10:   delta = ADDR_W'(2);
      default: delta = '1;
    endcase
    addr_out = addr_in + (wide ? {delta[ADDR_W-2:0], 1'b0} : delta);
  end
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int          NUM_EXT    = 30,
  parameter logic [15:0] FLASH_BASE = 16'h8000,
  parameter logic [15:0] FLASH_LAST = 16'hBFFF
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               desc_load,
  input  logic [63:0]        desc_bytes,
  input  logic               len_byte_low7,
  input  logic               sw_req,
  input  logic               prev_done,
  input  logic [NUM_EXT-1:0] ext_trig,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic               mem_en,
  output logic               mem_we,
  output logic               mem_wide,
  output logic [ADDR_W-1:0]  mem_addr,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic               active,
  output logic               done
);
  localparam int NPTR = 2;

  dma_state_e        state;
  dma_cfg_t          cfg_in, cfg_q;
  logic              low7_q;
  logic [ADDR_W-1:0] ptr_q   [NPTR];
  logic [ADDR_W-1:0] ptr_nxt [NPTR];
  logic [1:0]        inc_sel [NPTR];
  logic [CNT_W-1:0]  cnt_q, var_cnt;
  logic              first_q;
  logic              trig_hit;
  logic [DATA_W-1:0] rd_item;
  logic              dst_flash;
  logic              in_zero, cfg_zero;
  logic [CNT_W-1:0]  in_start, cfg_start;
  logic              mem_en_q, mem_we_q, done_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [DATA_W-1:0] mem_wdata_q;

  dma_desc_unpack u_unpack (.raw(desc_bytes), .cfg(cfg_in));

  dma_trig_select #(.NUM_EXT(NUM_EXT)) u_trig (
    .code(cfg_q.trig), .sw_req(sw_req), .prev_done(prev_done),
    .ext_trig(ext_trig), .hit(trig_hit)
  );

  assign rd_item = cfg_q.wide ? mem_rdata : {8'h00, mem_rdata[7:0]};

  dma_len_calc #(.LEN_W(LEN_W)) u_len (
    .vlen(cfg_q.vlen), .len(cfg_q.len), .wide(cfg_q.wide),
    .low7(low7_q), .first_item(rd_item[LEN_W-1:0]), .cnt(var_cnt)
  );

  assign inc_sel[0] = cfg_q.sinc;
  assign inc_sel[1] = cfg_q.dinc;

  for (genvar p = 0; p < NPTR; p++) begin : g_ptr
    dma_addr_step #(.ADDR_W(ADDR_W)) u_step (
      .addr_in(ptr_q[p]), .inc_code(inc_sel[p]),
      .wide(cfg_q.wide), .addr_out(ptr_nxt[p])
    );
  end

  // Count to start with: the fixed length, or a placeholder of one that
  // the first captured item replaces in data-derived modes.
  always_comb begin
    in_zero   = len_is_reserved(cfg_in.vlen) ||
                (len_is_fixed(cfg_in.vlen) && (cfg_in.len == '0));
    cfg_zero  = len_is_reserved(cfg_q.vlen) ||
                (len_is_fixed(cfg_q.vlen) && (cfg_q.len == '0));
    in_start  = len_is_fixed(cfg_in.vlen) ? {1'b0, cfg_in.len} : CNT_W'(1);
    cfg_start = len_is_fixed(cfg_q.vlen) ? {1'b0, cfg_q.len} : CNT_W'(1);
    dst_flash = (ptr_q[1] >= FLASH_BASE) && (ptr_q[1] <= FLASH_LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      cfg_q       <= '0;
      low7_q      <= 1'b0;
      ptr_q[0]    <= '0;
      ptr_q[1]    <= '0;
      cnt_q       <= '0;
      first_q     <= 1'b0;
      mem_en_q    <= 1'b0;
      mem_we_q    <= 1'b0;
      mem_addr_q  <= '0;
      mem_wdata_q <= '0;
      done_q      <= 1'b0;
    end else begin
      mem_en_q <= 1'b0;
      mem_we_q <= 1'b0;
      done_q   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (desc_load) begin
            cfg_q    <= cfg_in;
            low7_q   <= len_byte_low7;
            ptr_q[0] <= cfg_in.src;
            ptr_q[1] <= cfg_in.dst;
            cnt_q    <= in_start;
            first_q  <= 1'b1;
            if (in_zero) begin
              state  <= ST_FIN;
              done_q <= 1'b1;
            end else begin
              state  <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (trig_hit) begin
            state      <= ST_RD;
            mem_en_q   <= 1'b1;
            mem_addr_q <= ptr_q[0];
          end
        end
        ST_RD: state <= ST_CAP;
        ST_CAP: begin
          state       <= ST_WR;
          mem_en_q    <= !dst_flash;
          mem_we_q    <= !dst_flash;
          mem_addr_q  <= ptr_q[1];
          mem_wdata_q <= rd_item;
          first_q     <= 1'b0;
          if (first_q && !len_is_fixed(cfg_q.vlen)) cnt_q <= var_cnt;
        end
        ST_WR: begin
          ptr_q[0] <= ptr_nxt[0];
          ptr_q[1] <= ptr_nxt[1];
          cnt_q    <= cnt_q - CNT_W'(1);
          if (cnt_q == CNT_W'(1)) begin
            state  <= ST_FIN;
            done_q <= 1'b1;
          end else if (cfg_q.tmode[0]) begin
            state      <= ST_RD;
            mem_en_q   <= 1'b1;
            mem_addr_q <= ptr_nxt[0];
          end else begin
            state <= ST_ARM;
          end
        end
        ST_FIN: begin
          if (cfg_q.tmode[1] && !cfg_zero) begin
            ptr_q[0] <= cfg_q.src;
            ptr_q[1] <= cfg_q.dst;
            cnt_q    <= cfg_start;
            first_q  <= 1'b1;
            state    <= ST_ARM;
          end else begin
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en    = mem_en_q;
  assign mem_we    = mem_we_q;
  assign mem_wide  = cfg_q.wide;
  assign mem_addr  = mem_addr_q;
  assign mem_wdata = mem_wdata_q;
  assign done      = done_q;
  assign active    = (state != ST_IDLE);
endmodule

// File: rtl/dma_chan_engine_chk.sv
module dma_chan_engine_chk #(
  parameter logic [15:0] FLASH_BASE = 16'h8000,
  parameter logic [15:0] FLASH_LAST = 16'hBFFF
) (
  input logic        clk,
  input logic        rst,
  input logic        mem_en,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic        done,
  input logic        active
);
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_idle_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    !active |-> !mem_en);

  assert_read_gap_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_en && !mem_we) |=> !mem_en);

  assert_write_after_read_R12: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> $past(mem_en && !mem_we, 2));

  assert_no_flash_write_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_en && mem_we) |-> !((mem_addr >= FLASH_BASE) && (mem_addr <= FLASH_LAST)));

  assert_reset_quiet_R14: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !mem_en && !active));
endmodule

bind dma_chan_engine dma_chan_engine_chk #(
  .FLASH_BASE(FLASH_BASE), .FLASH_LAST(FLASH_LAST)
) u_chk (.*);

// File: tb/dma_chan_engine_test.sv
`timescale 1ns/1ps
module dma_chan_engine_test;
  localparam int NUM_EXT = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        desc_load = 1'b0;
  logic [63:0] desc_bytes = '0;
  logic        len_byte_low7 = 1'b0;
  logic        sw_req = 1'b0;
  logic        prev_done = 1'b0;
  logic [NUM_EXT-1:0] ext_trig = '0;
  logic [15:0] mem_rdata;
  logic        mem_en, mem_we, mem_wide, active, done;
  logic [15:0] mem_addr, mem_wdata;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  dma_chan_engine #(
    .NUM_EXT(NUM_EXT), .FLASH_BASE(16'h00C0), .FLASH_LAST(16'h00FF)
  ) uut (
    .clk(clk), .rst(rst), .desc_load(desc_load), .desc_bytes(desc_bytes),
    .len_byte_low7(len_byte_low7), .sw_req(sw_req), .prev_done(prev_done),
    .ext_trig(ext_trig), .mem_rdata(mem_rdata), .mem_en(mem_en),
    .mem_we(mem_we), .mem_wide(mem_wide), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .active(active), .done(done)
  );

  // Memory model, 256 bytes, little-endian words, one-cycle read latency.
  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  logic       fill_go = 1'b0;
  logic [7:0] fill_src = '0;
  logic [15:0] fill_n = '0;
  logic       fill_wide = 1'b0;
  int wr_cnt = 0, rd_cnt = 0, wide_cnt = 0, done_cnt = 0;

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (fill_go) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem[fill_src] <= fill_n[7:0];
      if (fill_wide) mem[8'(fill_src + 8'd1)] <= fill_n[15:8];
      wr_cnt <= 0; rd_cnt <= 0; wide_cnt <= 0; done_cnt <= 0;
    end else begin
      if (done) done_cnt <= done_cnt + 1;
      if (mem_en && mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_wide) mem[8'(mem_addr[7:0] + 8'd1)] <= mem_wdata[15:8];
        wr_cnt <= wr_cnt + 1;
        if (mem_wide) wide_cnt <= wide_cnt + 1;
      end else if (mem_en) begin
        mem_rdata <= {mem_wide ? mem[8'(mem_addr[7:0] + 8'd1)] : 8'h00,
                      mem[mem_addr[7:0]]};
        rd_cnt <= rd_cnt + 1;
      end
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic fill(input logic [7:0] src, input logic [15:0] n, input logic w);
    @(negedge clk);
    fill_src = src; fill_n = n; fill_wide = w; fill_go = 1'b1;
    @(negedge clk); fill_go = 1'b0;
    for (int i = 0; i < 256; i++) exp_mem[i] = pat(i);
    exp_mem[src] = n[7:0];
    if (w) exp_mem[8'(src + 8'd1)] = n[15:8];
  endtask

  function automatic logic [7:0] step8(input logic [1:0] inc, input logic w);
    logic [7:0] d;
    case (inc)
      2'b00:   d = 8'h00;
      2'b01:   d = 8'h01;
      2'b10:   d = 8'h02;
      default: d = 8'hFF;
    endcase
    return w ? 8'(d << 1) : d;
  endfunction

  task automatic ref_copy(input logic [63:0] d, input int cnt);
    logic [7:0] s, t;
    logic w;
    s = d[55:48]; t = d[39:32]; w = d[15];
    for (int i = 0; i < cnt; i++) begin
      if (t < 8'hC0) begin
        exp_mem[t] = exp_mem[s];
        if (w) exp_mem[8'(t + 8'd1)] = exp_mem[8'(s + 8'd1)];
      end
      s = s + step8(d[7:6], w);
      t = t + step8(d[5:4], w);
    end
  endtask

  task automatic load_desc(input logic [63:0] d, input logic m8);
    @(negedge clk);
    desc_bytes = d; len_byte_low7 = m8; desc_load = 1'b1;
    @(negedge clk); desc_load = 1'b0;
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_req = 1'b1;
    @(negedge clk); sw_req = 1'b0;
  endtask

  task automatic pulse_prev();
    @(negedge clk); prev_done = 1'b1;
    @(negedge clk); prev_done = 1'b0;
  endtask

  task automatic pulse_ext(input int idx);
    @(negedge clk); ext_trig[idx] = 1'b1;
    @(negedge clk); ext_trig = '0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic mem_cmp(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_mem[i]) bad++;
    chk(req, "memory image mismatches", bad, 0);
  endtask

  // Vector: descriptor[96:33], low7[32], first item[31:16], expected items[15:0]
  localparam int NVEC = 12;
  localparam logic [96:0] VEC [NVEC] = '{
    {64'h0010_0060_0005_2050, 1'b0, 16'h0011, 16'd5}, // R2 fixed bytes
    {64'h0020_0070_0003_A050, 1'b0, 16'h0011, 16'd3}, // R2 R6 fixed words
    {64'h0010_0060_2014_2050, 1'b0, 16'h0004, 16'd5}, // R3 n+1
    {64'h0010_0060_4014_2050, 1'b1, 16'h0086, 16'd6}, // R3 n, low 7 bits
    {64'h0010_0060_6014_2050, 1'b0, 16'h0003, 16'd5}, // R3 n+2
    {64'h0010_0060_8014_2050, 1'b0, 16'h0002, 16'd5}, // R3 n+3
    {64'h0010_0060_2004_2050, 1'b0, 16'h0009, 16'd4}, // R4 capped by length
    {64'h0010_0060_400A_A050, 1'b0, 16'hE003, 16'd3}, // R3 word, low 13 bits
    {64'h0030_0080_0004_20D0, 1'b0, 16'h0011, 16'd4}, // R6 source decrement
    {64'h0010_0060_0003_2090, 1'b0, 16'h0011, 16'd3}, // R6 source +2 items
    {64'h0010_0060_A003_2050, 1'b0, 16'h0011, 16'd0}, // R5 reserved code
    {64'h0010_0060_E003_2050, 1'b0, 16'h0011, 16'd3}  // R2 code 111
  };

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] d;
    do_reset();
    @(negedge clk);
    chk("R14", "active after reset", active, 0);
    chk("R14", "done after reset", done, 0);
    chk("R14", "mem_en after reset", mem_en, 0);

    for (int i = 0; i < NVEC; i++) begin
      d = VEC[i][96:33];
      do_reset();
      fill(d[55:48], VEC[i][31:16], d[15]);
      ref_copy(d, int'(VEC[i][15:0]));
      load_desc(d, VEC[i][32]);
      pulse_sw();
      settle(60);
      chk("R2/R3/R4/R5", "item count", wr_cnt, VEC[i][15:0]);
      chk("R12", "wide writes", wide_cnt, d[15] ? VEC[i][15:0] : 16'd0);
      chk("R11", "done cycles", done_cnt, 1);
      chk("R1/R6", "copy result", 0, 0);
      mem_cmp("R1/R6");
      chk("R8", "idle after block", active, 0);
    end

    // R7 R8 R13: single mode on ext_trig[0] (select code 2)
    d = 64'h0010_0060_0003_0250;
    do_reset(); fill(8'h10, 16'h0000, 1'b0); ref_copy(d, 3);
    load_desc(d, 1'b0);
    pulse_ext(1); settle(8);
    chk("R7", "wrong external trigger", wr_cnt, 0);
    pulse_prev(); settle(8);
    chk("R7", "prev_done on code 2", wr_cnt, 0);
    pulse_ext(0); settle(8);
    chk("R8", "one item per trigger", wr_cnt, 1);
    chk("R8", "still armed", active, 1);
    load_desc(64'h0010_0090_0009_2050, 1'b0);
    settle(4);
    chk("R13", "load while busy moves nothing", wr_cnt, 1);
    pulse_ext(0); settle(8);
    pulse_ext(0); settle(8);
    chk("R8", "items after three triggers", wr_cnt, 3);
    chk("R11", "single mode done", done_cnt, 1);
    mem_cmp("R13");
    chk("R8", "idle after count", active, 0);

    // R7: select code 1 follows prev_done
    d = 64'h0010_0060_0002_2150;
    do_reset(); fill(8'h10, 16'h0000, 1'b0);
    load_desc(d, 1'b0);
    pulse_prev(); settle(20);
    chk("R7", "chained start", wr_cnt, 2);

    // R9: repeated block reloads and re-arms
    d = 64'h0010_0060_0002_6050;
    do_reset(); fill(8'h10, 16'h0000, 1'b0); ref_copy(d, 2);
    load_desc(d, 1'b0);
    pulse_sw(); settle(20);
    chk("R9", "first pass items", wr_cnt, 2);
    chk("R9", "re-armed", active, 1);
    pulse_sw(); settle(20);
    chk("R9", "second pass items", wr_cnt, 4);
    chk("R9", "second done", done_cnt, 2);
    mem_cmp("R9");

    // R10: destination in flash window
    d = 64'h0010_00C0_0002_2050;
    do_reset(); fill(8'h10, 16'h0000, 1'b0); ref_copy(d, 2);
    load_desc(d, 1'b0);
    pulse_sw(); settle(20);
    chk("R10", "suppressed writes", wr_cnt, 0);
    chk("R10", "reads still made", rd_cnt, 2);
    chk("R10", "completion", done_cnt, 1);
    mem_cmp("R10");

    // R5: reserved code 110, no trigger needed, no access
    do_reset(); fill(8'h10, 16'h0000, 1'b0);
    load_desc(64'h0010_0060_C003_2050, 1'b0);
    settle(10);
    chk("R5", "done without access", done_cnt, 1);
    chk("R5", "no reads", rd_cnt, 0);
    chk("R5", "back to idle", active, 0);

    // R2: fixed length zero
    do_reset(); fill(8'h10, 16'h0000, 1'b0);
    load_desc(64'h0010_0060_0000_2050, 1'b0);
    pulse_sw(); settle(10);
    chk("R2", "zero length writes", wr_cnt, 0);
    chk("R2", "zero length done", done_cnt, 1);

    // R4: length ceiling of zero still moves the first item
    do_reset(); fill(8'h10, 16'h0005, 1'b0);
    load_desc(64'h0010_0060_2000_2050, 1'b0);
    pulse_sw(); settle(20);
    chk("R4", "floor of one item", wr_cnt, 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule